// File: doc/BRIEF.md
# Single-Slope Multichannel Conversion Timer

This block is the digital half of a single-slope converter that serves four analog channels at once. All channels share one voltage ramp, built by a constant current charging an external capacitor. A rising edge on the PWM synchronisation input starts a conversion. The block then releases the capacitor from reset and starts one shared 12-bit counter. Each channel's comparator goes high when the ramp crosses that channel's input. On the first clock edge that sees a comparator high, the block stores the counter value as that channel's result. The count is the crossing time, and so it measures the channel's voltage.

The fourth channel is fed through an external 4-to-1 multiplexer. The block latches the two select bits at the start of each conversion and drives them out. Three of the codes pick auxiliary inputs. The fourth code routes the internal reference through, so software can calibrate the ramp slope. A select input chooses the counter's time base: either every clock, or a slower enable derived from it. When every channel has captured, or the counter reaches its top value, the block grounds the capacitor again and raises a done flag.

Top module: `ss_adc_timer`

## Requirements
- R1: After reset, cap_reset is 1, busy and conv_done are 0, aux_mux_sel is 00, and every result port reads 0.
- R2: A rising edge on pwm_sync seen while idle starts a conversion. At the next clock edge, busy goes to 1, cap_reset goes to 0, conv_done goes to 0, and the counter restarts from 0.
- R3: With clk_src_sel = 0, the counter advances on every clock. A comparator first sampled high on the k-th clock edge after the start edge stores the value k-1.
- R4: With clk_src_sel = 1, the counter advances on every second clock. A comparator first sampled high on the k-th edge after the start edge stores floor((k-1)/2).
- R5: Only the first high sample of each channel in a conversion is stored. Later toggles of that comparator leave its result unchanged.
- R6: A channel whose comparator never goes high stores 4095. With clk_src_sel = 0, a conversion in which some channel never trips ends on the 4096th edge after the start edge.
- R7: conv_done rises, and busy falls, on the same edge that captures the last channel. conv_done stays high until the next start and is never high together with busy.
- R8: aux_mux_sel takes the value of aux_sel_in at the start edge and holds it for the whole conversion. The codes are 00, 01 and 10 for auxiliary inputs 0 to 2, and 11 for the reference used for calibration.
- R9: A pwm_sync rising edge during a conversion is ignored. The counter does not restart and the results are those of the original conversion.
- R10: The result ports hold their values while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_sync | input | 1 | Conversion start; a rising edge begins a conversion |
| clk_src_sel | input | 1 | Counter time base: 0 counts every clock, 1 counts every second clock |
| aux_sel_in | input | 2 | Auxiliary multiplexer code requested for the next conversion |
| cmp_in | input | 4 | Comparator outputs; bit 3 is the multiplexed channel |
| aux_mux_sel | output | 2 | Latched multiplexer select driven to the analog side |
| cap_reset | output | 1 | High holds the ramp capacitor discharged |
| busy | output | 1 | Conversion in progress |
| conv_done | output | 1 | All four results of the last conversion are valid |
| res_ch0 | output | 12 | Result of channel 0 |
| res_ch1 | output | 12 | Result of channel 1 |
| res_ch2 | output | 12 | Result of channel 2 |
| res_ch3 | output | 12 | Result of the multiplexed channel |

## Verification
The hardest states to reach from the ports are those where the exact edge matters. Examples are a comparator that never trips, so the conversion ends at saturation, and a sync edge that arrives in the middle of a ramp. The driver counts clock edges from the start edge and raises each comparator at a chosen offset. It can also pulse the comparator low and high again, pulse pwm_sync mid-ramp, or leave a channel silent for the full 4096-edge ramp. The expected count comes from the offset alone, and the scoreboard compares all four channels when conv_done rises.

// File: rtl/ss_adc_pkg.sv
package ss_adc_pkg;
    localparam int unsigned CNT_W = 12;
    localparam int unsigned N_CH  = 4;
    localparam int unsigned SEL_W = 2;
    localparam int unsigned SLOW_DIV = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        AUX_IN0 = 2'b00,
        AUX_IN1 = 2'b01,
        AUX_IN2 = 2'b10,
        AUX_CAL = 2'b11
    } aux_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } conv_st_e;

    function automatic cnt_t cnt_top();
        return '1;
    endfunction
endpackage

// File: rtl/ss_adc_tick_gen.sv
module ss_adc_tick_gen #(
    parameter int unsigned DIV = ss_adc_pkg::SLOW_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph <= '0;
        end else if (run) begin
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        end
    end

    assign tick = slow ? (ph == PH_LAST) : 1'b1;
endmodule

// File: rtl/ss_adc_ramp_cnt.sv
module ss_adc_ramp_cnt #(
    parameter int unsigned W = ss_adc_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt,
    output logic         at_max
);
    assign at_max = (cnt == {W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en && !at_max) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ss_adc_cap_ch.sv
module ss_adc_cap_ch #(
    parameter int unsigned W = ss_adc_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         active,
    input  logic         trip,
    input  logic         fin,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] res,
    output logic         hit_nxt
);
    logic hit;

    assign hit_nxt = hit | (active & trip);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit <= 1'b0;
            res <= '0;
        end else if (clr) begin
            hit <= 1'b0;
        end else if (active && !hit) begin
            if (trip) begin
                res <= cnt;
                hit <= 1'b1;
            end else if (fin) begin
                res <= {W{1'b1}};
                hit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ss_adc_timer.sv
module ss_adc_timer
    import ss_adc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pwm_sync,
    input  logic                    clk_src_sel,
    input  logic [SEL_W-1:0]        aux_sel_in,
    input  logic [N_CH-1:0]         cmp_in,
    output logic [SEL_W-1:0]        aux_mux_sel,
    output logic                    cap_reset,
    output logic                    busy,
    output logic                    conv_done,
    output logic [CNT_W-1:0]        res_ch0,
    output logic [CNT_W-1:0]        res_ch1,
    output logic [CNT_W-1:0]        res_ch2,
    output logic [CNT_W-1:0]        res_ch3
);
    conv_st_e        st;
    aux_sel_e        sel_q;
    logic            sync_q;
    logic            start;
    logic            active;
    logic            fin;
    logic            tick;
    logic            at_max;
    cnt_t            cnt_w;
    cnt_t            res_arr [N_CH];
    logic [N_CH-1:0] hit_nxt;

    assign active = (st == ST_RAMP);
    assign start  = pwm_sync & ~sync_q & ~active;
    assign fin    = active & ((&hit_nxt) | at_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            st        <= ST_IDLE;
            conv_done <= 1'b0;
            sel_q     <= AUX_IN0;
        end else begin
            sync_q <= pwm_sync;
            if (start) begin
                st        <= ST_RAMP;
                conv_done <= 1'b0;
                sel_q     <= aux_sel_e'(aux_sel_in);
            end else if (fin) begin
                st        <= ST_IDLE;
                conv_done <= 1'b1;
            end
        end
    end

    ss_adc_tick_gen #(.DIV(SLOW_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .run  (active),
        .slow (clk_src_sel),
        .tick (tick)
    );

    ss_adc_ramp_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .en     (active & tick),
        .cnt    (cnt_w),
        .at_max (at_max)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        ss_adc_cap_ch #(.W(CNT_W)) u_cap (
            .clk     (clk),
            .rst     (rst),
            .clr     (start),
            .active  (active),
            .trip    (cmp_in[g]),
            .fin     (fin),
            .cnt     (cnt_w),
            .res     (res_arr[g]),
            .hit_nxt (hit_nxt[g])
        );
    end

    assign aux_mux_sel = sel_q;
    assign cap_reset   = ~active;
    assign busy        = active;
    assign res_ch0     = res_arr[0];
    assign res_ch1     = res_arr[1];
    assign res_ch2     = res_arr[2];
    assign res_ch3     = res_arr[3];
endmodule

// File: rtl/ss_adc_timer_chk.sv
module ss_adc_timer_chk
    import ss_adc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pwm_sync,
    input logic             busy,
    input logic             conv_done,
    input logic             cap_reset,
    input logic [SEL_W-1:0] aux_mux_sel,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] r0,
    input logic [CNT_W-1:0] r1,
    input logic [CNT_W-1:0] r2,
    input logic [CNT_W-1:0] r3
);
    AST_START_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (pwm_sync && !$past(pwm_sync) && !busy) |=> (busy && !cap_reset)); // R2

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt >= $past(cnt))); // R9

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(aux_mux_sel)); // R8

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(conv_done && busy)); // R7

    AST_DONE_AFTER_RAMP: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_done) |-> $past(busy)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> ($stable(r0) && $stable(r1) && $stable(r2) && $stable(r3))); // R10
endmodule

bind ss_adc_timer ss_adc_timer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwm_sync    (pwm_sync),
    .busy        (busy),
    .conv_done   (conv_done),
    .cap_reset   (cap_reset),
    .aux_mux_sel (aux_mux_sel),
    .cnt         (cnt_w),
    .r0          (res_ch0),
    .r1          (res_ch1),
    .r2          (res_ch2),
    .r3          (res_ch3)
);

// File: tb/ss_adc_timer_tb_top.sv
module ss_adc_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        pwm_sync;
    logic        clk_src_sel;
    logic [1:0]  aux_sel_in;
    logic [3:0]  cmp_in;
    logic [1:0]  aux_mux_sel;
    logic        cap_reset;
    logic        busy;
    logic        conv_done;
    logic [11:0] res_ch0, res_ch1, res_ch2, res_ch3;

    int tests_run = 0;
    int tests_failed = 0;

    typedef struct { logic [11:0] r [4]; } exp_t;
    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    ss_adc_timer dut_i (
        .clk(clk), .rst(rst), .pwm_sync(pwm_sync), .clk_src_sel(clk_src_sel),
        .aux_sel_in(aux_sel_in), .cmp_in(cmp_in), .aux_mux_sel(aux_mux_sel),
        .cap_reset(cap_reset), .busy(busy), .conv_done(conv_done),
        .res_ch0(res_ch0), .res_ch1(res_ch1), .res_ch2(res_ch2), .res_ch3(res_ch3)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares results when conv_done rises
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst && conv_done && !prev_done) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3/R4/R5/R6 ch0", res_ch0, e.r[0]);
                chk("R3/R4/R5/R6 ch1", res_ch1, e.r[1]);
                chk("R3/R4/R5/R6 ch2", res_ch2, e.r[2]);
                chk("R3/R4/R5/R6 ch3", res_ch3, e.r[3]);
            end
        end
        prev_done = rst ? 1'b0 : conv_done;
    end

    // driver: trip offsets in edges after start; 0 means never trips
    task automatic run_conv(input int t [4], input bit slow, input logic [1:0] sel,
                            input bit glitch, input bit retrig, input bit chsel,
                            input string tag);
        exp_t e;
        int   k;
        int   tmax;
        bit   all_trip;
        all_trip = 1'b1;
        tmax = 0;
        for (int i = 0; i < 4; i++) begin
            if (t[i] == 0) begin
                e.r[i] = 12'd4095;
                all_trip = 1'b0;
            end else begin
                e.r[i] = slow ? 12'(t[i] / 2) : 12'(t[i]);
                if (t[i] > tmax) tmax = t[i];
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        clk_src_sel = slow;
        aux_sel_in  = sel;
        pwm_sync    = 1'b1;
        @(negedge clk);
        pwm_sync = 1'b0;
        k = 0;
        chk({"R2 busy ", tag}, busy, 1);
        chk({"R2 cap_reset ", tag}, cap_reset, 0);
        chk({"R2 done low ", tag}, conv_done, 0);
        while (!conv_done && k < 20000) begin
            @(negedge clk);
            k++;
            if (conv_done) break;
            if (k == 2) chk({"R8 sel latched ", tag}, aux_mux_sel, sel);
            if (chsel && k == 3) aux_sel_in = ~sel;
            if (chsel && k == 6) chk({"R8 sel held ", tag}, aux_mux_sel, sel);
            if (retrig && k == 4) pwm_sync = 1'b1;
            if (retrig && k == 5) pwm_sync = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (t[i] != 0 && k == t[i]) cmp_in[i] = 1'b1;
                if (glitch && t[i] != 0 && k == t[i] + 1) cmp_in[i] = 1'b0;
                if (glitch && t[i] != 0 && k == t[i] + 3) cmp_in[i] = 1'b1;
            end
        end
        if (all_trip) chk({"R7 done edge ", tag}, k, tmax + 1);
        else if (!slow) chk({"R6 saturation edge ", tag}, k, 4096);
        chk({"R7 busy low ", tag}, busy, 0);
        chk({"R7 cap_reset high ", tag}, cap_reset, 1);
        cmp_in = 4'b0;
        @(negedge clk);
        chk({"R7 done held ", tag}, conv_done, 1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t [4];
        logic [11:0] h0;
        rst = 1'b1; pwm_sync = 1'b0; clk_src_sel = 1'b0;
        aux_sel_in = 2'b00; cmp_in = 4'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cap_reset", cap_reset, 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", conv_done, 0);
        chk("R1 aux_mux_sel", aux_mux_sel, 0);
        chk("R1 results", {res_ch0, res_ch1, res_ch2, res_ch3}, 0);

        // R3 fast counting, distinct offsets, aux input 1
        t = '{5, 17, 300, 42};
        run_conv(t, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "fast");
        // R10 results held while idle
        h0 = res_ch2;
        repeat (20) @(negedge clk);
        chk("R10 idle hold", res_ch2, h0);

        // R5 later toggles ignored
        t = '{9, 3, 60, 25};
        run_conv(t, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, "glitch");

        // R6 channel 2 never trips
        t = '{11, 200, 0, 7};
        run_conv(t, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "sat");

        // R4 slow time base
        t = '{10, 11, 501, 64};
        run_conv(t, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, "slow");

        // R8 calibration code held against select changes
        t = '{30, 31, 32, 33};
        run_conv(t, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, "cal");

        // R9 sync during ramp ignored
        t = '{80, 20, 150, 12};
        run_conv(t, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, "retrig");

        repeat (5) @(negedge clk);
        chk("R7 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule